// File: doc/BRIEF.md
# Blank-Gated Programmable Timer

A 16-bit up-counter with a register interface. On each bus-clock cycle it may advance by one, driven by one of four tick sources: every bus-clock cycle, one cycle in 16 or one cycle in 256 from a free-running prescaler, or each rising edge of the horizontal-blank input. Counting can be held back by a gate taken from either the horizontal-blank or the vertical-blank input. The gate either allows counting only while the gate is low, or holds the counter until a chosen edge and then lets it run.

A compare register raises an equal flag when the count matches it. If zero return is set, the counter also restarts from zero on that tick. Wrapping past 0xFFFF raises an overflow flag. Both flags are sticky and are cleared by writing ones to them. Each flag can drive the interrupt output through its own enable. An instance built with the hold option copies the count into a hold register on each rising edge of the capture strobe. Software normally starts the timer by writing the mode register and then writing zero to the count.

The gate is handled by a four-state machine. GS_FREE: the gate is off and counting is always allowed. GS_LEVEL: counting is allowed while the selected gate is low. GS_ARMED: counting is held until the start edge. GS_RUN: counting is allowed. Every mode write re-selects the state: gate off goes to GS_FREE, gate mode 0 goes to GS_LEVEL, and gate modes 1 to 3 go to GS_ARMED. In GS_ARMED, the selected edge moves the machine to GS_RUN. GS_RUN is left only through a later mode write.

Top module: `blank_gated_timer`

## Requirements
- R1: After reset the count, mode, compare and hold registers read zero and irq_out is low.
- R2: Mode bits [1:0] pick the tick: 0 every bus-clock cycle, 1 one cycle in every 16, 2 one cycle in every 256, 3 each rising edge of hblank_in. The count rises by at most one per cycle.
- R3: With mode bit 7 clear the count does not change, except through a count write.
- R4: A tick taken while count equals compare sets the equal flag (mode bit 10). If mode bit 6 is set, that tick loads zero instead of count+1.
- R5: A tick at 0xFFFF wraps the count to 0 and sets the overflow flag (mode bit 11), whether or not bit 9 is set.
- R6: Writing 1 to mode bit 10 or 11 clears that flag, and writing 0 leaves it. A set in the same cycle wins over the clear.
- R7: irq_out = (bit 8 AND equal flag) OR (bit 9 AND overflow flag).
- R8: With mode bit 2 set and mode bits [5:4] = 0, counting is allowed only while the gate is low. Bit 3 chooses the gate: 0 is hblank_in and 1 is vblank_in.
- R9: With mode bit 2 set and mode bits [5:4] = 1, 2 or 3, counting is held after the mode write until a rising, falling or either edge of the gate. It then continues whatever the gate does.
- R10: The register slot is bus_addr[7:4]: 0 count, 1 mode, 2 compare, 3 hold. Bits 31:16 always read zero, and other slots read zero.
- R11: In hold-enabled builds, the hold register loads the count on each rising edge of capture_in and keeps its value while the strobe stays high. Without the hold option, slot 3 reads zero.
- R12: A count write loads bits 15:0 in place of that cycle's tick. The next tick counts up from the written value.
- R13: hblank_in, vblank_in and capture_in pass through two synchronizer flops and an edge register. A change reaches the count no sooner than the third clock edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte address; bits 7:4 select the slot |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| hblank_in | input | 1 | Horizontal blank, asynchronous |
| vblank_in | input | 1 | Vertical blank, asynchronous |
| capture_in | input | 1 | Hold capture strobe, asynchronous |
| irq_out | output | 1 | Compare or overflow interrupt |

## Verification
The checker assumes that reset is applied before the first checked edge. It also assumes that each level on the blank and capture inputs lasts long enough to pass the synchronizer, so that no gate or capture edge is lost. The stimulus keeps every such level for at least three clock cycles and changes inputs only on the falling clock edge. Every register write lasts one cycle, and no two writes are issued at once. Expected counts for the divided tick sources are measured over whole prescaler periods, so the result does not depend on the prescaler phase.

// File: rtl/gtmr_pkg.sv
package gtmr_pkg;

    typedef enum logic [1:0] {
        CLK_BUS    = 2'd0,
        CLK_DIV_LO = 2'd1,
        CLK_DIV_HI = 2'd2,
        CLK_HBLANK = 2'd3
    } clk_sel_e;

    typedef enum logic [1:0] {
        GM_LOW  = 2'd0,
        GM_RISE = 2'd1,
        GM_FALL = 2'd2,
        GM_BOTH = 2'd3
    } gate_mode_e;

    typedef enum logic [1:0] {
        GS_FREE  = 2'd0,
        GS_LEVEL = 2'd1,
        GS_ARMED = 2'd2,
        GS_RUN   = 2'd3
    } gate_state_e;

    // Stored configuration, bits 9..0 of the mode register (MSB first).
    typedef struct packed {
        logic       ovf_irq_en;
        logic       cmp_irq_en;
        logic       count_en;
        logic       zero_ret;
        gate_mode_e gmode;
        logic       gate_vsel;
        logic       gate_en;
        clk_sel_e   csel;
    } mode_cfg_t;

    localparam int CFG_W   = $bits(mode_cfg_t);
    localparam int BIT_EQF = CFG_W;
    localparam int BIT_OVF = CFG_W + 1;
    localparam int MODE_W  = CFG_W + 2;

    localparam logic [3:0] SLOT_COUNT = 4'd0;
    localparam logic [3:0] SLOT_MODE  = 4'd1;
    localparam logic [3:0] SLOT_COMP  = 4'd2;
    localparam logic [3:0] SLOT_HOLD  = 4'd3;

    localparam int SYNC_HB  = 0;
    localparam int SYNC_VB  = 1;
    localparam int SYNC_CAP = 2;
    localparam int SYNC_N   = 3;

endpackage

// File: rtl/gtmr_prescale.sv
module gtmr_prescale #(
    parameter int LO_LOG = 4,
    parameter int HI_LOG = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_lo,
    output logic tick_hi
);
    logic [HI_LOG-1:0] div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign tick_lo = &div_q[LO_LOG-1:0];
    assign tick_hi = &div_q;
endmodule

// File: rtl/gtmr_sync.sv
module gtmr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_in};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign level = chain_q[STAGES-1];
    assign rise  = level & ~prev_q;
    assign fall  = ~level & prev_q;
endmodule

// File: rtl/gtmr_gate_fsm.sv
module gtmr_gate_fsm
    import gtmr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_load,
    input  logic        load_gate_en,
    input  gate_mode_e  load_gmode,
    input  gate_mode_e  run_gmode,
    input  logic        gate_lvl,
    input  logic        gate_rise,
    input  logic        gate_fall,
    output logic        count_allow,
    output gate_state_e state
);
    gate_state_e state_q, state_d;
    logic        start_edge;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GS_FREE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (run_gmode)
            GM_LOW:  start_edge = 1'b0;
            GM_RISE: start_edge = gate_rise;
            GM_FALL: start_edge = gate_fall;
            GM_BOTH: start_edge = gate_rise | gate_fall;
        endcase
    end

    always_comb begin
        state_d = state_q;
        if (cfg_load) begin
            if (!load_gate_en) begin
                state_d = GS_FREE;
            end else if (load_gmode == GM_LOW) begin
                state_d = GS_LEVEL;
            end else begin
                state_d = GS_ARMED;
            end
        end else begin
            unique case (state_q)
                GS_FREE:  state_d = GS_FREE;
                GS_LEVEL: state_d = GS_LEVEL;
                GS_ARMED: if (start_edge) state_d = GS_RUN;
                GS_RUN:   state_d = GS_RUN;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            GS_FREE:  count_allow = 1'b1;
            GS_LEVEL: count_allow = ~gate_lvl;
            GS_ARMED: count_allow = 1'b0;
            GS_RUN:   count_allow = 1'b1;
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/blank_gated_timer.sv
module blank_gated_timer
    import gtmr_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter bit HAS_HOLD    = 1'b1,
    parameter int SYNC_STAGES = 2,
    parameter int DIV_LO_LOG  = 4,
    parameter int DIV_HI_LOG  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              hblank_in,
    input  logic              vblank_in,
    input  logic              capture_in,
    output logic              irq_out
);
    localparam int SLOT_LSB = 4;
    localparam int SLOT_W   = ADDR_W - SLOT_LSB;

    logic [SLOT_W-1:0] slot;
    logic              cnt_wr, mode_wr, comp_wr;
    logic [CNT_W-1:0]  count_q, comp_q, hold_q;
    mode_cfg_t         cfg_q, cfg_in;
    logic              equf_q, ovff_q;
    logic [MODE_W-1:0] mode_view;

    logic [SYNC_N-1:0] sy_lvl, sy_rise, sy_fall;
    logic              tick_lo, tick_hi, src_tick;
    logic              gate_lvl, gate_rise, gate_fall, allow;
    gate_state_e       gate_state;
    logic              step, cmp_hit, eq_set, ov_set;

    // ---------------- bus decode ----------------
    assign slot    = bus_addr[ADDR_W-1:SLOT_LSB];
    assign cnt_wr  = bus_wr && (slot == SLOT_W'(SLOT_COUNT));
    assign mode_wr = bus_wr && (slot == SLOT_W'(SLOT_MODE));
    assign comp_wr = bus_wr && (slot == SLOT_W'(SLOT_COMP));
    assign cfg_in  = mode_cfg_t'(bus_wdata[CFG_W-1:0]);

    // ---------------- input synchronizers ----------------
    logic [SYNC_N-1:0] raw_in;
    assign raw_in[SYNC_HB]  = hblank_in;
    assign raw_in[SYNC_VB]  = vblank_in;
    assign raw_in[SYNC_CAP] = capture_in;

    for (genvar gi = 0; gi < SYNC_N; gi++) begin : g_sync
        gtmr_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .async_in (raw_in[gi]),
            .level    (sy_lvl[gi]),
            .rise     (sy_rise[gi]),
            .fall     (sy_fall[gi])
        );
    end

    // ---------------- tick source ----------------
    gtmr_prescale #(.LO_LOG(DIV_LO_LOG), .HI_LOG(DIV_HI_LOG)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_lo (tick_lo),
        .tick_hi (tick_hi)
    );

    always_comb begin
        unique case (cfg_q.csel)
            CLK_BUS:    src_tick = 1'b1;
            CLK_DIV_LO: src_tick = tick_lo;
            CLK_DIV_HI: src_tick = tick_hi;
            CLK_HBLANK: src_tick = sy_rise[SYNC_HB];
        endcase
    end

    // ---------------- gate ----------------
    assign gate_lvl  = cfg_q.gate_vsel ? sy_lvl[SYNC_VB]  : sy_lvl[SYNC_HB];
    assign gate_rise = cfg_q.gate_vsel ? sy_rise[SYNC_VB] : sy_rise[SYNC_HB];
    assign gate_fall = cfg_q.gate_vsel ? sy_fall[SYNC_VB] : sy_fall[SYNC_HB];

    gtmr_gate_fsm u_gate (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_load     (mode_wr),
        .load_gate_en (cfg_in.gate_en),
        .load_gmode   (cfg_in.gmode),
        .run_gmode    (cfg_q.gmode),
        .gate_lvl     (gate_lvl),
        .gate_rise    (gate_rise),
        .gate_fall    (gate_fall),
        .count_allow  (allow),
        .state        (gate_state)
    );

    // ---------------- counter and flags ----------------
    assign step    = cfg_q.count_en & allow & src_tick & ~cnt_wr;
    assign cmp_hit = (count_q == comp_q);
    assign eq_set  = step & cmp_hit;
    assign ov_set  = step & (&count_q) & ~(cfg_q.zero_ret & cmp_hit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (cnt_wr) begin
            count_q <= bus_wdata[CNT_W-1:0];
        end else if (step) begin
            if (cfg_q.zero_ret && cmp_hit) begin
                count_q <= '0;
            end else begin
                count_q <= count_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            comp_q <= '0;
            equf_q <= 1'b0;
            ovff_q <= 1'b0;
        end else begin
            if (mode_wr) cfg_q  <= cfg_in;
            if (comp_wr) comp_q <= bus_wdata[CNT_W-1:0];
            equf_q <= (equf_q & ~(mode_wr & bus_wdata[BIT_EQF])) | eq_set;
            ovff_q <= (ovff_q & ~(mode_wr & bus_wdata[BIT_OVF])) | ov_set;
        end
    end

    // ---------------- optional hold ----------------
    if (HAS_HOLD) begin : g_hold
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hold_q <= '0;
            end else if (sy_rise[SYNC_CAP]) begin
                hold_q <= count_q;
            end
        end
    end else begin : g_no_hold
        assign hold_q = '0;
    end

    // ---------------- outputs ----------------
    assign mode_view = {ovff_q, equf_q, cfg_q};
    assign irq_out   = (cfg_q.cmp_irq_en & equf_q) | (cfg_q.ovf_irq_en & ovff_q);

    always_comb begin
        bus_rdata = '0;
        case (slot)
            SLOT_W'(SLOT_COUNT): bus_rdata[CNT_W-1:0]  = count_q;
            SLOT_W'(SLOT_MODE):  bus_rdata[MODE_W-1:0] = mode_view;
            SLOT_W'(SLOT_COMP):  bus_rdata[CNT_W-1:0]  = comp_q;
            SLOT_W'(SLOT_HOLD):  bus_rdata[CNT_W-1:0]  = hold_q;
            default:             bus_rdata = '0;
        endcase
    end

    logic unused_bits;
    assign unused_bits = ^{bus_wdata[DATA_W-1:CNT_W], bus_addr[SLOT_LSB-1:0],
                           sy_lvl[SYNC_CAP], sy_fall[SYNC_CAP]};
endmodule

// File: rtl/gtmr_checker.sv
module gtmr_checker
    import gtmr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CNT_W-1:0]  count_q,
    input logic [CNT_W-1:0]  comp_q,
    input logic [MODE_W-1:0] mode_q,
    input logic              step,
    input logic              count_wr,
    input gate_state_e       gstate,
    input logic              irq,
    input logic [DATA_W-1:0] rdata
);
    AST_CUE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q[7] && !count_wr) |=> $stable(count_q)); // R3

    AST_ZRET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (step && mode_q[6] && count_q == comp_q) |=> (count_q == '0)); // R4

    AST_EQ_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (step && count_q == comp_q) |=> mode_q[BIT_EQF]); // R4

    AST_OVF_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (step && (&count_q) && !(mode_q[6] && comp_q == count_q)) |=> (mode_q[BIT_OVF] && count_q == '0)); // R5

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q[BIT_EQF] && !mode_q[BIT_OVF]) |-> !irq); // R7

    AST_ARMED_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (gstate == GS_ARMED && !count_wr) |=> $stable(count_q)); // R9

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata[DATA_W-1:CNT_W] == '0)); // R10
endmodule

bind blank_gated_timer gtmr_checker #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .count_q  (count_q),
    .comp_q   (comp_q),
    .mode_q   (mode_view),
    .step     (step),
    .count_wr (cnt_wr),
    .gstate   (gate_state),
    .irq      (irq_out),
    .rdata    (bus_rdata)
);

// File: tb/blank_gated_timer_bench.sv
module blank_gated_timer_bench;
    localparam logic [7:0] A_CNT  = 8'h00;
    localparam logic [7:0] A_MODE = 8'h10;
    localparam logic [7:0] A_COMP = 8'h20;
    localparam logic [7:0] A_HOLD = 8'h30;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata, rdata_nh;
    logic        hblank_in = 1'b0, vblank_in = 1'b0, capture_in = 1'b0;
    logic        irq_out, irq_nh;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    blank_gated_timer u_blank_gated_timer (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hblank_in(hblank_in),
        .vblank_in(vblank_in), .capture_in(capture_in), .irq_out(irq_out)
    );

    blank_gated_timer #(.HAS_HOLD(1'b0)) u_blank_gated_timer_nohold (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_nh), .hblank_in(hblank_in),
        .vblank_in(vblank_in), .capture_in(capture_in), .irq_out(irq_nh)
    );

    typedef struct packed {
        logic [11:0] mode;
        logic [15:0] start;
        logic [15:0] comp;
        logic [15:0] span;
        logic [15:0] exp_cnt;
        logic        exp_eq;
        logic        exp_ov;
        logic        exp_irq;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{12'h080, 16'h0000, 16'hFFFF, 16'd20,  16'd20, 1'b0, 1'b0, 1'b0}, // R2 bus clock
        '{12'h0C0, 16'h0000, 16'h0005, 16'd20,  16'd2,  1'b1, 1'b0, 1'b0}, // R4 zero return
        '{12'h081, 16'h0000, 16'hFFFF, 16'd160, 16'd10, 1'b0, 1'b0, 1'b0}, // R2 divide by 16
        '{12'h082, 16'h0000, 16'hFFFF, 16'd512, 16'd2,  1'b0, 1'b0, 1'b0}, // R2 divide by 256
        '{12'h000, 16'h0007, 16'hFFFF, 16'd30,  16'd7,  1'b0, 1'b0, 1'b0}, // R3 count disabled
        '{12'h180, 16'h0000, 16'h0003, 16'd10,  16'd10, 1'b1, 1'b0, 1'b1}, // R4 R7 compare, no return
        '{12'h080, 16'hFFF0, 16'h8000, 16'd20,  16'd4,  1'b0, 1'b1, 1'b0}, // R5 wrap, irq off
        '{12'h280, 16'hFFF0, 16'h8000, 16'd20,  16'd4,  1'b0, 1'b1, 1'b1}, // R5 R7 wrap, irq on
        '{12'h0C0, 16'h0000, 16'h0000, 16'd5,   16'd0,  1'b1, 1'b0, 1'b0}, // R4 compare zero
        '{12'h180, 16'h0000, 16'h0003, 16'd2,   16'd2,  1'b0, 1'b0, 1'b0}  // R4 before match
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic prep(input logic [15:0] comp, input logic [15:0] start);
        wr(A_MODE, 32'h0000_0C00);
        wr(A_MODE, 32'h0000_0C00);
        wr(A_COMP, {16'h0, comp});
        wr(A_CNT,  {16'h0, start});
    endtask

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_CNT, v);  chk("R1 count after reset", v, 0);
        rd(A_MODE, v); chk("R1 mode after reset", v, 0);
        rd(A_COMP, v); chk("R1 compare after reset", v, 0);
        rd(A_HOLD, v); chk("R1 hold after reset", v, 0);
        chk("R1 irq after reset", {31'h0, irq_out}, 0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            prep(VECS[i].comp, VECS[i].start);
            wr(A_MODE, {20'h0, VECS[i].mode});
            repeat (int'(VECS[i].span)) @(negedge clk);
            rd(A_CNT, v);
            chk($sformatf("R2/R3/R4/R5 vec%0d count", i), v, {16'h0, VECS[i].exp_cnt});
            rd(A_MODE, v);
            chk($sformatf("R4 vec%0d equal flag", i), {31'h0, v[10]}, {31'h0, VECS[i].exp_eq});
            chk($sformatf("R5 vec%0d overflow flag", i), {31'h0, v[11]}, {31'h0, VECS[i].exp_ov});
            chk($sformatf("R7 vec%0d irq", i), {31'h0, irq_out}, {31'h0, VECS[i].exp_irq});
        end

        // R12 count write priority
        prep(16'hFFFF, 16'h0000);
        wr(A_MODE, 32'h080);
        wr(A_CNT, 32'h0000_0100);
        rd(A_CNT, v); chk("R12 written count exact", v, 32'h100);
        repeat (3) @(negedge clk);
        rd(A_CNT, v); chk("R12 counts on from written value", v, 32'h103);

        // R6 flag clearing
        prep(16'h8000, 16'hFFFE);
        wr(A_MODE, 32'h280);
        repeat (4) @(negedge clk);
        rd(A_MODE, v); chk("R6 overflow flag set", {31'h0, v[11]}, 1);
        chk("R7 irq from overflow", {31'h0, irq_out}, 1);
        wr(A_MODE, 32'h280);
        rd(A_MODE, v); chk("R6 write 0 keeps flag", {31'h0, v[11]}, 1);
        wr(A_MODE, 32'hA80);
        rd(A_MODE, v); chk("R6 write 1 clears flag", {31'h0, v[11]}, 0);
        chk("R7 irq drops after clear", {31'h0, irq_out}, 0);

        // R8 level gate on hblank
        hblank_in = 1'b1;
        prep(16'hFFFF, 16'h0000);
        wr(A_MODE, 32'h084);
        repeat (20) @(negedge clk);
        rd(A_CNT, v); chk("R8 gate high holds count", v, 0);
        hblank_in = 1'b0;
        repeat (12) @(negedge clk);
        rd(A_CNT, v); chk("R8 R13 gate low counts after sync", v, 10);
        hblank_in = 1'b1;
        prep(16'hFFFF, 16'h0000);
        wr(A_MODE, 32'h08C);
        repeat (10) @(negedge clk);
        rd(A_CNT, v); chk("R8 vblank selected, hblank ignored", v, 10);
        hblank_in = 1'b0;

        // R9 rising start on vblank
        prep(16'hFFFF, 16'h0000);
        wr(A_MODE, 32'h09C);
        repeat (10) @(negedge clk);
        rd(A_CNT, v); chk("R9 armed holds count", v, 0);
        vblank_in = 1'b1;
        repeat (13) @(negedge clk);
        rd(A_CNT, v); chk("R9 R13 runs after rising edge", v, 10);
        vblank_in = 1'b0;
        repeat (10) @(negedge clk);
        rd(A_CNT, v); chk("R9 keeps running after gate falls", v, 20);

        // R9 falling start
        prep(16'hFFFF, 16'h0000);
        wr(A_MODE, 32'h0AC);
        vblank_in = 1'b1;
        repeat (10) @(negedge clk);
        rd(A_CNT, v); chk("R9 falling mode ignores rise", v, 0);
        vblank_in = 1'b0;
        repeat (13) @(negedge clk);
        rd(A_CNT, v); chk("R9 falling mode starts", v, 10);

        // R9 either edge
        prep(16'hFFFF, 16'h0000);
        wr(A_MODE, 32'h0BC);
        vblank_in = 1'b1;
        repeat (13) @(negedge clk);
        rd(A_CNT, v); chk("R9 either-edge mode starts", v, 10);
        vblank_in = 1'b0;

        // R2 hblank as tick source
        prep(16'hFFFF, 16'h0000);
        wr(A_MODE, 32'h083);
        for (int p = 0; p < 5; p++) begin
            hblank_in = 1'b1; repeat (3) @(negedge clk);
            hblank_in = 1'b0; repeat (3) @(negedge clk);
        end
        repeat (5) @(negedge clk);
        rd(A_CNT, v); chk("R2 hblank edges counted", v, 5);

        // R11 hold capture
        wr(A_MODE, 32'h000);
        wr(A_CNT, 32'h1234);
        capture_in = 1'b1;
        repeat (5) @(negedge clk);
        rd(A_HOLD, v); chk("R11 hold captures on rise", v, 32'h1234);
        wr(A_CNT, 32'h0055);
        repeat (5) @(negedge clk);
        rd(A_HOLD, v); chk("R11 steady strobe ignored", v, 32'h1234);
        capture_in = 1'b0;
        repeat (4) @(negedge clk);
        capture_in = 1'b1;
        repeat (5) @(negedge clk);
        rd(A_HOLD, v); chk("R11 second capture", v, 32'h0055);
        chk("R11 no-hold build reads zero", rdata_nh, 0);

        // R10 map and upper bits
        wr(A_CNT, 32'hFFFF_ABCD);
        rd(A_CNT, v); chk("R10 count upper bits zero", v, 32'h0000_ABCD);
        wr(A_COMP, 32'h1234_5678);
        rd(A_COMP, v); chk("R10 compare upper bits zero", v, 32'h0000_5678);
        rd(8'h40, v); chk("R10 unmapped slot reads zero", v, 0);
        rd(A_MODE, v); chk("R10 mode readback", v, 32'h0000_0000);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule